// File: doc/BRIEF.md
# Indirection Keystream Generator Core

This block generates 32-bit pseudo-random words by walking a 256-word state table and updating it as it goes. At each index i, the current table word picks an indirect address. An accumulator is rotated and has the word half a table away added to it. The table slot is then overwritten with a new value. Finally a second indirect lookup yields one result word. A full pass covers all 256 indices and fills a 256-word result table, which the host then reads one word at a time.

Before the first pass, the host writes the state table through a seed port and sets the accumulator A and the previous-result register B. It then pulses `start`. Each step moves through two pipeline stages of four cycles each, and the stages work on adjacent steps at the same time. A and B, like the state table, carry over from one pass to the next, so further passes with no reseed extend the same sequence.

Top module: `ibaa_core`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `rd_data` are all 0.
- R2: While idle, `seed_we` writes `seed_data` into state word `seed_addr`, and `init_we` loads A from `init_a` and B from `init_b`.
- R3: For step i, with x = M[i], the accumulator becomes A = rotl19(A) + M[(i+128) mod 256]. Here rotl19(a) = (a<<19)|(a>>13) on 32 bits, and an index always keeps only its low 8 bits.
- R4: Each step computes y = M[x mod 256] + A + B and writes y into M[i]. Every later read in the same pass, including the lookup in the same step, sees the new value.
- R5: Each step sets B = M[(y>>8) mod 256] + x and stores B in R[i]. After a pass, all 256 result words equal a sequential model bit for bit.
- R6: A, B and M keep their values between passes, so a second pass with no reseed continues the sequential model.
- R7: A pass takes 257 four-cycle slots. `done` is high in the cycle that starts 1028 rising edges after the edge that samples `start`, and `busy` drops at that same edge.
- R8: `done` stays high for exactly one cycle.
- R9: A `start` pulse that arrives during a pass has no effect. The pass still ends after 1028 cycles with unchanged results.
- R10: `seed_we` and `init_we` have no effect during a pass. The state table, and hence the next pass's results, are unchanged.
- R11: `rd_data` returns R[`rd_addr`] one cycle after the address is sampled, and holds its value until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_we | input | 1 | Write one state-table word (idle only) |
| seed_addr | input | 8 | State-table address for seeding |
| seed_data | input | 32 | State-table seed word |
| init_we | input | 1 | Load A and B (idle only) |
| init_a | input | 32 | Initial accumulator value |
| init_b | input | 32 | Initial previous-result value |
| start | input | 1 | Begin a pass (ignored while busy) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at end of pass |
| rd_addr | input | 8 | Result-table read address |
| rd_data | output | 32 | Result word, one cycle latency |

## Verification
The bench compares all 256 result words against an arithmetic model in the bench. It does this for four seeds: a linear ramp, all ones with nonzero A and B, a multiplicative hash pattern, and all zeros. The ramp and the hash pattern create many self-referencing lookups in which y>>8 lands on the index just written, which exposes stale-read hazards. All ones with nonzero A and B exposes errors in the rotate and the adds. All zeros checks that nothing leaks in from uninitialised state. A pass with no reseed, which receives a stray start and stray seed and init writes, is followed by one more pass. These two separate carried state from ignored inputs.

// File: rtl/ibaa_pkg.sv
package ibaa_pkg;
    parameter int unsigned WORD_W = 32;
    parameter int unsigned IDX_W  = 8;
    parameter int unsigned ROT    = 19;

    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int unsigned HALF  = DEPTH / 2;
    localparam int unsigned SLOTS = DEPTH + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [IDX_W:0]    slot_t;

    typedef enum logic [1:0] {PH_0, PH_1, PH_2, PH_3} phase_e;

    // Hand-off record from the first stage to the second
    typedef struct packed {
        word_t x;
        word_t a;
        idx_t  idx;
    } s2_t;

    function automatic word_t mix(input word_t v);
        return (v << ROT) | (v >> (WORD_W - ROT));
    endfunction

    function automatic idx_t low_idx(input word_t v);
        return v[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/ibaa_seq.sv
module ibaa_seq
    import ibaa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output logic   busy,
    output logic   done,
    output phase_e phase,
    output slot_t  slot,
    output logic   s1_act,
    output logic   s2_act
);
    localparam slot_t LAST = slot_t'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            phase <= PH_0;
            slot  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                busy  <= start;
                phase <= PH_0;
                slot  <= '0;
            end else begin
                phase <= phase_e'(phase + 2'd1);
                if (phase == PH_3) begin
                    if (slot == LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
            end
        end
    end

    assign s1_act = busy && !slot[IDX_W];
    assign s2_act = busy && (slot != '0);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_ends_pass: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    a_r7_phase_advances: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done || phase == phase_e'($past(phase) + 2'd1)));
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && phase != PH_3) |=> (busy && $stable(slot)));
endmodule

// File: rtl/ibaa_state_mem.sv
module ibaa_state_mem
    import ibaa_pkg::*;
#(
    parameter int unsigned NRD = 2
) (
    input  logic  clk,
    input  logic  we,
    input  idx_t  waddr,
    input  word_t wdata,
    input  idx_t  raddr [NRD],
    output word_t rdata [NRD]
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read ports; a write lands at the edge, so reads in
    // the following cycle observe it.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/ibaa_result_mem.sv
module ibaa_result_mem
    import ibaa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  waddr,
    input  word_t wdata,
    input  idx_t  raddr,
    output word_t rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= mem[raddr];
    end
endmodule

// File: rtl/ibaa_core.sv
module ibaa_core
    import ibaa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_we,
    input  logic [IDX_W-1:0]  seed_addr,
    input  logic [WORD_W-1:0] seed_data,
    input  logic              init_we,
    input  logic [WORD_W-1:0] init_a,
    input  logic [WORD_W-1:0] init_b,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    phase_e phase;
    slot_t  slot;
    logic   s1_act, s2_act;

    ibaa_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .phase(phase), .slot(slot), .s1_act(s1_act), .s2_act(s2_act)
    );

    word_t acc_a, prev_b;
    word_t s1_x, s1_far;
    word_t s2_m, s2_y;
    s2_t   s2;
    idx_t  s1_idx;

    idx_t  m_raddr [2];
    word_t m_rdata [2];
    logic  eng_we, m_we, r_we;
    idx_t  m_waddr;
    word_t m_wdata, b_next;

    assign s1_idx = slot[IDX_W-1:0];

    // Port 0 serves stage 1: own slot, then the slot half a table away.
    assign m_raddr[0] = (phase == PH_0) ? s1_idx : s1_idx + idx_t'(HALF);
    // Port 1 serves stage 2: lookup by x, then lookup by y>>IDX_W.
    assign m_raddr[1] = (phase == PH_0) ? low_idx(s2.x) : low_idx(s2_y >> IDX_W);

    assign eng_we  = s2_act && (phase == PH_2);
    assign m_we    = eng_we || (seed_we && !busy);
    assign m_waddr = eng_we ? s2.idx : seed_addr;
    assign m_wdata = eng_we ? s2_y   : seed_data;

    assign b_next  = m_rdata[1] + s2.x;
    assign r_we    = s2_act && (phase == PH_3);

    ibaa_state_mem #(.NRD(2)) u_mstate (
        .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
        .raddr(m_raddr), .rdata(m_rdata)
    );

    ibaa_result_mem u_result (
        .clk(clk), .rst(rst), .we(r_we), .waddr(s2.idx), .wdata(b_next),
        .raddr(rd_addr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_a  <= '0;
            prev_b <= '0;
            s1_x   <= '0;
            s1_far <= '0;
            s2_m   <= '0;
            s2_y   <= '0;
            s2     <= '0;
        end else begin
            if (!busy && init_we) begin
                acc_a  <= init_a;
                prev_b <= init_b;
            end
            if (s1_act) begin
                unique case (phase)
                    PH_0: s1_x   <= m_rdata[0];
                    PH_1: s1_far <= m_rdata[0];
                    PH_2: acc_a  <= mix(acc_a) + s1_far;
                    PH_3: s2     <= '{x: s1_x, a: acc_a, idx: s1_idx};
                endcase
            end
            if (s2_act) begin
                unique case (phase)
                    PH_0: s2_m   <= m_rdata[1];
                    PH_1: s2_y   <= s2_m + s2.a + prev_b;
                    PH_2: ;
                    PH_3: prev_b <= b_next;
                endcase
            end
        end
    end

    a_r5_result_follows_update: assert property (@(posedge clk) disable iff (rst)
        eng_we |=> r_we);
    a_r10_no_engine_write_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !eng_we);
endmodule

// File: tb/ibaa_core_tb.sv
`timescale 1ns/1ps
module ibaa_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_we = 1'b0;
    logic [7:0]  seed_addr = '0;
    logic [31:0] seed_data = '0;
    logic        init_we = 1'b0;
    logic [31:0] init_a = '0, init_b = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] bm [256];
    logic [31:0] br [256];
    logic [31:0] ba, bb;

    always #2.5 clk = ~clk;

    ibaa_core u_dut (
        .clk(clk), .rst(rst), .seed_we(seed_we), .seed_addr(seed_addr),
        .seed_data(seed_data), .init_we(init_we), .init_a(init_a),
        .init_b(init_b), .start(start), .busy(busy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rotl19(input logic [31:0] v);
        return {v[12:0], v[31:13]};
    endfunction

    // Sequential reference for one pass (R3, R4, R5, R6)
    task automatic model_pass();
        logic [31:0] x, y;
        for (int i = 0; i < 256; i++) begin
            x = bm[i];
            ba = rotl19(ba) + bm[(i + 128) % 256];
            y = bm[x[7:0]] + ba + bb;
            bm[i] = y;
            bb = bm[y[15:8]] + x;
            br[i] = bb;
        end
    endtask

    function automatic logic [31:0] pat(input int kind, input int k);
        logic [31:0] kk = 32'(k);
        case (kind)
            0: return kk * 32'h0101_0101 + 32'h0003_0507;
            1: return 32'hFFFF_FFFF;
            2: return (kk + 32'd1) * 32'h9E37_79B9 ^ (kk << 11);
            default: return 32'h0;
        endcase
    endfunction

    // R2: seeding through the idle load ports
    task automatic seed(input int kind, input logic [31:0] a0, input logic [31:0] b0);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            seed_we = 1'b1; seed_addr = 8'(k); seed_data = pat(kind, k);
            bm[k] = pat(kind, k);
        end
        @(negedge clk);
        seed_we = 1'b0;
        init_we = 1'b1; init_a = a0; init_b = b0;
        ba = a0; bb = b0;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    // Runs one pass; optionally throws in a stray start and stray loads.
    task automatic run_pass(input bit stray, input string tag);
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(posedge clk);
            n++;
            #1;
            if (stray && n == 40)  start = 1'b1;
            if (stray && n == 41)  start = 1'b0;
            if (stray && n == 600) begin
                seed_we = 1'b1; seed_addr = 8'd3; seed_data = 32'hDEAD_BEEF;
                init_we = 1'b1; init_a = 32'h1234_5678; init_b = 32'h8765_4321;
            end
            if (stray && n == 601) begin
                seed_we = 1'b0; init_we = 1'b0;
            end
        end
        chk(n == 1028, {tag, " R7 pass length"}, 32'(n), 32'd1028);
        chk(!busy, {tag, " R7 busy falls with done"}, 32'(busy), 32'd0);
        @(posedge clk);
        #1;
        chk(!done, {tag, " R8 done single cycle"}, 32'(done), 32'd0);
        model_pass();
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            rd_addr = 8'(k);
            @(posedge clk);
            #1;
            chk(rd_data === br[k], {tag, " R5 result word"}, rd_data, br[k]);
        end
    endtask

    initial begin
        #(150000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
        chk(rd_data == 32'd0, "R1 rd_data after reset", rd_data, 32'd0);

        // Ramp seed, zero A/B (R2, R3, R4, R5)
        seed(0, 32'd0, 32'd0);
        run_pass(1'b0, "ramp");
        read_all("ramp");

        // R11: value holds until the edge, then follows the new address
        @(negedge clk); rd_addr = 8'd3;
        @(posedge clk); #1;
        @(negedge clk); rd_addr = 8'd7;
        #1;
        chk(rd_data === br[3], "R11 holds before edge", rd_data, br[3]);
        @(posedge clk); #1;
        chk(rd_data === br[7], "R11 one-cycle latency", rd_data, br[7]);

        // R6, R9, R10: no reseed, stray start and loads during the pass
        run_pass(1'b1, "carry+stray");
        read_all("R6 R9 carry+stray");
        run_pass(1'b0, "after-stray");
        read_all("R10 after-stray");

        // All ones with nonzero A and B (R3)
        seed(1, 32'hA5A5_0F0F, 32'h0000_0001);
        run_pass(1'b0, "ones");
        read_all("R3 ones");

        // Hash pattern, two passes (R4, R6)
        seed(2, 32'h8000_0001, 32'hFEDC_BA98);
        run_pass(1'b0, "hash1");
        read_all("R4 hash1");
        run_pass(1'b0, "hash2");
        read_all("R6 hash2");

        // All zeros (R2)
        seed(3, 32'd0, 32'd0);
        run_pass(1'b0, "zero");
        read_all("R2 zero");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule